// File: doc/BRIEF.md
# AHB Region Guard

This block sits between one AHB master and one AHB memory port and decides, transfer by transfer, whether the memory may see it. Eight address windows are held in registers loaded through a plain parallel write port. Each window has an inclusive lower and upper bound, an enable bit and four access rights. When a transfer is allowed, every address-phase signal reaches the memory unchanged and the memory's response returns to the master. When it is refused, the memory port sees IDLE and the master receives a two-cycle AHB ERROR response.

The first refused transfer raises a sticky interrupt line and records the offending address and attributes. From then on, until software pulses the clear input, the block refuses every transfer and does not record new ones. A global stop input refuses all traffic without raising the interrupt. A privilege override input replaces the privileged bit that goes to memory. The check itself always uses the privileged bit the master sent.

Top module: `ahb_region_guard`

## Requirements
- R1: A transfer hits window i when window i is enabled and its start address <= HADDR <= its end address (both ends inclusive). A disabled window never hits. A write on the config port takes effect from the next cycle.
- R2: When several windows hit, only the lowest-numbered hit window decides. Its rights are applied even when a higher-numbered hit window would allow the transfer.
- R3: The rights field is 4 bits: bit0 privileged read, bit1 privileged write, bit2 user read, bit3 user write. Privileged means m_hprot[1]=1, and write means m_hwrite=1.
- R4: A NONSEQ or SEQ transfer that hits no window is a violation.
- R5: While an allowed transfer is presented, s_haddr, s_htrans, s_hwrite, s_hsize, s_hwdata and s_hprot equal the master's signals. In its data phase, m_hrdata, m_hready and m_hresp follow the memory's signals.
- R6: In the cycle a refused transfer is presented, s_htrans is IDLE (2'b00). The next cycle gives m_hresp=1 with m_hready=0, and the cycle after gives m_hresp=1 with m_hready=1.
- R7: A violation sets viol_irq at the clock edge that accepts the transfer. viol_irq stays set until a one-cycle flag_clr pulse clears it.
- R8: On a violation, err_addr takes HADDR and err_ctrl takes {htrans[13:12], hmaster[11:8], hprot[7:4], hsize[3:1], hwrite[0]}. Both read zero after reset.
- R9: While viol_irq is set, every transfer is refused as in R6 and err_addr and err_ctrl are not updated. Normal checking resumes after the clear.
- R10: While stop_en=1, every transfer is refused as in R6. viol_irq and the error registers are not changed.
- R11: With prot_ovr_en=1, s_hprot[1] equals prot_ovr_val while the other bits pass through. The rights check still uses m_hprot[1].
- R12: After reset, viol_irq=0, m_hready=1, m_hresp=0, and every window is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Window write strobe |
| cfg_idx | input | 3 | Window index to write |
| cfg_lo | input | 32 | Window start address (inclusive) |
| cfg_hi | input | 32 | Window end address (inclusive) |
| cfg_en | input | 1 | Window enable |
| cfg_perm | input | 4 | Window access rights |
| stop_en | input | 1 | Refuse all transfers |
| prot_ovr_en | input | 1 | Replace downstream privileged bit |
| prot_ovr_val | input | 1 | Replacement privileged bit value |
| flag_clr | input | 1 | Clear pulse for the violation flag |
| m_haddr | input | 32 | Master address |
| m_htrans | input | 2 | Master transfer type |
| m_hwrite | input | 1 | Master write |
| m_hsize | input | 3 | Master size |
| m_hprot | input | 4 | Master protection |
| m_hmaster | input | 4 | Master identifier |
| m_hwdata | input | 32 | Master write data |
| m_hrdata | output | 32 | Read data to master |
| m_hready | output | 1 | Ready to master |
| m_hresp | output | 1 | Response to master |
| s_haddr | output | 32 | Memory address |
| s_htrans | output | 2 | Memory transfer type |
| s_hwrite | output | 1 | Memory write |
| s_hsize | output | 3 | Memory size |
| s_hprot | output | 4 | Memory protection |
| s_hwdata | output | 32 | Memory write data |
| s_hrdata | input | 32 | Memory read data |
| s_hready | input | 1 | Memory ready |
| s_hresp | input | 1 | Memory response |
| viol_irq | output | 1 | Sticky violation interrupt |
| err_addr | output | 32 | Captured violating address |
| err_ctrl | output | 14 | Captured violating attributes |

## Verification
The assertions assume that the master follows AHB: it holds its address phase while m_hready is low, and it does not depend on the memory side finishing a transfer that was never forwarded. They also assume that the memory port returns s_hready=1 after an IDLE. The stimulus meets these assumptions: a memory model is always ready and OKAY, each transfer is one address phase followed by IDLE, and the window configuration changes only between transfers.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  // AHB transfer type codes
  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;

  // Rights bit positions inside a window's permission field
  localparam int PB_PRIV_RD = 0;
  localparam int PB_PRIV_WR = 1;
  localparam int PB_USER_RD = 2;
  localparam int PB_USER_WR = 3;
  localparam int PERM_W     = 4;

  typedef enum logic [1:0] {
    RSP_OK   = 2'b00,
    RSP_ERR1 = 2'b01,
    RSP_ERR2 = 2'b10
  } rsp_state_t;
endpackage

// File: rtl/mpu_region_file.sv
module mpu_region_file
  import mpu_pkg::*;
#(
  parameter int N_RGN = 8,
  parameter int AW    = 32,
  localparam int IW   = $clog2(N_RGN)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [IW-1:0]                  idx,
  input  logic [AW-1:0]                  lo,
  input  logic [AW-1:0]                  hi,
  input  logic                           en,
  input  logic [PERM_W-1:0]              perm,
  output logic [N_RGN-1:0][AW-1:0]       rg_lo,
  output logic [N_RGN-1:0][AW-1:0]       rg_hi,
  output logic [N_RGN-1:0]               rg_en,
  output logic [N_RGN-1:0][PERM_W-1:0]   rg_perm
);
  for (genvar g = 0; g < N_RGN; g++) begin : g_rgn
    logic load;
    assign load = we && (idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rg_lo[g]   <= '0;
        rg_hi[g]   <= '0;
        rg_en[g]   <= 1'b0;
        rg_perm[g] <= '0;
      end else if (load) begin
        rg_lo[g]   <= lo;
        rg_hi[g]   <= hi;
        rg_en[g]   <= en;
        rg_perm[g] <= perm;
      end
    end
  end
endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import mpu_pkg::*;
#(
  parameter int N_RGN = 8,
  parameter int AW    = 32
) (
  input  logic [AW-1:0]                  addr,
  input  logic [N_RGN-1:0][AW-1:0]       rg_lo,
  input  logic [N_RGN-1:0][AW-1:0]       rg_hi,
  input  logic [N_RGN-1:0]               rg_en,
  input  logic [N_RGN-1:0][PERM_W-1:0]   rg_perm,
  output logic                           hit_any,
  output logic [PERM_W-1:0]              hit_perm
);
  logic [N_RGN-1:0] hit_vec;

  for (genvar g = 0; g < N_RGN; g++) begin : g_cmp
    assign hit_vec[g] = rg_en[g] && (addr >= rg_lo[g]) && (addr <= rg_hi[g]);
  end

  // Lowest index wins: scan from the top so the last assignment is the winner
  always_comb begin
    hit_any  = 1'b0;
    hit_perm = '0;
    for (int i = N_RGN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_any  = 1'b1;
        hit_perm = rg_perm[i];
      end
    end
  end
endmodule

// File: rtl/mpu_err_resp.sv
module mpu_err_resp
  import mpu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic err_wait,
  output logic err_last
);
  rsp_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      RSP_OK:   if (start) st_d = RSP_ERR1;
      RSP_ERR1: st_d = RSP_ERR2;
      RSP_ERR2: st_d = start ? RSP_ERR1 : RSP_OK;
      default:  st_d = RSP_OK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RSP_OK;
    else        st_q <= st_d;
  end

  assign err_wait = (st_q == RSP_ERR1);
  assign err_last = (st_q == RSP_ERR2);
endmodule

// File: rtl/ahb_region_guard.sv
module ahb_region_guard
  import mpu_pkg::*;
#(
  parameter int N_RGN = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int MW    = 4,
  localparam int IW   = $clog2(N_RGN),
  localparam int ECW  = 10 + MW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IW-1:0]     cfg_idx,
  input  logic [AW-1:0]     cfg_lo,
  input  logic [AW-1:0]     cfg_hi,
  input  logic              cfg_en,
  input  logic [PERM_W-1:0] cfg_perm,
  input  logic              stop_en,
  input  logic              prot_ovr_en,
  input  logic              prot_ovr_val,
  input  logic              flag_clr,
  input  logic [AW-1:0]     m_haddr,
  input  logic [1:0]        m_htrans,
  input  logic              m_hwrite,
  input  logic [2:0]        m_hsize,
  input  logic [3:0]        m_hprot,
  input  logic [MW-1:0]     m_hmaster,
  input  logic [DW-1:0]     m_hwdata,
  output logic [DW-1:0]     m_hrdata,
  output logic              m_hready,
  output logic              m_hresp,
  output logic [AW-1:0]     s_haddr,
  output logic [1:0]        s_htrans,
  output logic              s_hwrite,
  output logic [2:0]        s_hsize,
  output logic [3:0]        s_hprot,
  output logic [DW-1:0]     s_hwdata,
  input  logic [DW-1:0]     s_hrdata,
  input  logic              s_hready,
  input  logic              s_hresp,
  output logic              viol_irq,
  output logic [AW-1:0]     err_addr,
  output logic [ECW-1:0]    err_ctrl
);
  logic [N_RGN-1:0][AW-1:0]     rg_lo, rg_hi;
  logic [N_RGN-1:0]             rg_en;
  logic [N_RGN-1:0][PERM_W-1:0] rg_perm;
  logic                         hit_any;
  logic [PERM_W-1:0]            hit_perm;
  logic                         err_wait, err_last;
  logic                         flag_q, flag_d;
  logic [AW-1:0]                eaddr_q, eaddr_d;
  logic [ECW-1:0]               ectrl_q, ectrl_d;
  logic                         accept, permit, deny, viol, start_err;
  logic [1:0]                   right_sel;

  mpu_region_file #(.N_RGN(N_RGN), .AW(AW)) u_rfile (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .idx     (cfg_idx),
    .lo      (cfg_lo),
    .hi      (cfg_hi),
    .en      (cfg_en),
    .perm    (cfg_perm),
    .rg_lo   (rg_lo),
    .rg_hi   (rg_hi),
    .rg_en   (rg_en),
    .rg_perm (rg_perm)
  );

  mpu_region_match #(.N_RGN(N_RGN), .AW(AW)) u_match (
    .addr     (m_haddr),
    .rg_lo    (rg_lo),
    .rg_hi    (rg_hi),
    .rg_en    (rg_en),
    .rg_perm  (rg_perm),
    .hit_any  (hit_any),
    .hit_perm (hit_perm)
  );

  mpu_err_resp u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_err),
    .err_wait (err_wait),
    .err_last (err_last)
  );

  // Rights selection: always uses the master's own privileged bit
  assign right_sel = {~m_hprot[1], m_hwrite};
  assign permit    = hit_any && hit_perm[right_sel];

  assign m_hready  = err_wait ? 1'b0 : (err_last ? 1'b1 : s_hready);
  assign m_hresp   = (err_wait || err_last) ? 1'b1 : s_hresp;
  assign m_hrdata  = s_hrdata;

  assign accept    = m_htrans[1] && m_hready;
  assign deny      = stop_en || flag_q || !permit;
  assign start_err = accept && deny;
  assign viol      = accept && !stop_en && !flag_q && !permit;

  // Downstream address phase
  assign s_haddr   = m_haddr;
  assign s_hwrite  = m_hwrite;
  assign s_hsize   = m_hsize;
  assign s_hwdata  = m_hwdata;
  assign s_htrans  = (err_wait || (m_htrans[1] && deny)) ? TR_IDLE : m_htrans;

  always_comb begin
    s_hprot = m_hprot;
    if (prot_ovr_en) s_hprot[1] = prot_ovr_val;
  end

  // Sticky flag and capture registers
  always_comb begin
    flag_d  = flag_q;
    eaddr_d = eaddr_q;
    ectrl_d = ectrl_q;
    if (viol) begin
      flag_d  = 1'b1;
      eaddr_d = m_haddr;
      ectrl_d = {m_htrans, m_hmaster, m_hprot, m_hsize, m_hwrite};
    end else if (flag_clr) begin
      flag_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      eaddr_q <= '0;
      ectrl_q <= '0;
    end else begin
      flag_q  <= flag_d;
      if (viol) begin
        eaddr_q <= eaddr_d;
        ectrl_q <= ectrl_d;
      end
    end
  end

  assign viol_irq = flag_q;
  assign err_addr = eaddr_q;
  assign err_ctrl = ectrl_q;
endmodule

// File: rtl/mpu_guard_chk.sv
module mpu_guard_chk #(
  parameter int AW  = 32,
  parameter int ECW = 14
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     m_htrans,
  input logic           m_hready,
  input logic           m_hresp,
  input logic [3:0]     m_hprot,
  input logic [1:0]     s_htrans,
  input logic [3:0]     s_hprot,
  input logic           stop_en,
  input logic           prot_ovr_en,
  input logic           prot_ovr_val,
  input logic           flag_clr,
  input logic           viol_irq,
  input logic [AW-1:0]  err_addr,
  input logic [ECW-1:0] err_ctrl,
  input logic           deny
);
  a_r6_idle_on_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (m_htrans[1] && m_hready && deny) |-> (s_htrans == 2'b00));

  a_r6_err_first: assert property (@(posedge clk) disable iff (!rst_n)
    (m_htrans[1] && m_hready && deny) |=> (m_hresp && !m_hready));

  a_r6_err_second: assert property (@(posedge clk) disable iff (!rst_n)
    (m_hresp && !m_hready) |=> (m_hresp && m_hready));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_irq && !flag_clr) |=> viol_irq);

  a_r9_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    viol_irq |=> ($stable(err_addr) && $stable(err_ctrl)));

  a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_en && m_htrans[1]) |-> (s_htrans == 2'b00));

  a_r10_stop_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_en && !viol_irq) |=> !viol_irq);

  a_r11_ovr_bit: assert property (@(posedge clk) disable iff (!rst_n)
    prot_ovr_en |-> (s_hprot[1] == prot_ovr_val));

  a_r11_ovr_others: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ({s_hprot[3:2], s_hprot[0]} == {m_hprot[3:2], m_hprot[0]}));
endmodule

bind ahb_region_guard mpu_guard_chk #(.AW(AW), .ECW(ECW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .m_htrans     (m_htrans),
  .m_hready     (m_hready),
  .m_hresp      (m_hresp),
  .m_hprot      (m_hprot),
  .s_htrans     (s_htrans),
  .s_hprot      (s_hprot),
  .stop_en      (stop_en),
  .prot_ovr_en  (prot_ovr_en),
  .prot_ovr_val (prot_ovr_val),
  .flag_clr     (flag_clr),
  .viol_irq     (viol_irq),
  .err_addr     (err_addr),
  .err_ctrl     (err_ctrl),
  .deny         (deny)
);

// File: tb/sim_ahb_region_guard.sv
module sim_ahb_region_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_en;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_lo, cfg_hi;
  logic [3:0]  cfg_perm;
  logic        stop_en, prot_ovr_en, prot_ovr_val, flag_clr;
  logic [31:0] m_haddr, m_hwdata, m_hrdata;
  logic [1:0]  m_htrans;
  logic        m_hwrite, m_hready, m_hresp;
  logic [2:0]  m_hsize;
  logic [3:0]  m_hprot, m_hmaster;
  logic [31:0] s_haddr, s_hwdata, s_hrdata;
  logic [1:0]  s_htrans;
  logic        s_hwrite, s_hready, s_hresp;
  logic [2:0]  s_hsize;
  logic [3:0]  s_hprot;
  logic        viol_irq;
  logic [31:0] err_addr;
  logic [13:0] err_ctrl;

  int checks = 0;
  int errs   = 0;

  always #10 clk = ~clk;

  ahb_region_guard u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_lo(cfg_lo),
    .cfg_hi(cfg_hi), .cfg_en(cfg_en), .cfg_perm(cfg_perm), .stop_en(stop_en),
    .prot_ovr_en(prot_ovr_en), .prot_ovr_val(prot_ovr_val), .flag_clr(flag_clr),
    .m_haddr(m_haddr), .m_htrans(m_htrans), .m_hwrite(m_hwrite), .m_hsize(m_hsize),
    .m_hprot(m_hprot), .m_hmaster(m_hmaster), .m_hwdata(m_hwdata), .m_hrdata(m_hrdata),
    .m_hready(m_hready), .m_hresp(m_hresp), .s_haddr(s_haddr), .s_htrans(s_htrans),
    .s_hwrite(s_hwrite), .s_hsize(s_hsize), .s_hprot(s_hprot), .s_hwdata(s_hwdata),
    .s_hrdata(s_hrdata), .s_hready(s_hready), .s_hresp(s_hresp), .viol_irq(viol_irq),
    .err_addr(err_addr), .err_ctrl(err_ctrl)
  );

  // {addr[34:3], write[2], priv[1], allowed[0]}
  localparam logic [34:0] VECS [0:8] = '{
    {32'h0000_1000, 1'b0, 1'b1, 1'b1},  // R1 start inclusive, R3 priv read
    {32'h0000_1FFF, 1'b0, 1'b0, 1'b0},  // R2 lowest window refuses user read
    {32'h0000_2000, 1'b1, 1'b0, 1'b1},  // R3 user write via window 1
    {32'h0000_3FFF, 1'b1, 1'b1, 1'b1},  // R1 end inclusive
    {32'h0000_4000, 1'b0, 1'b1, 1'b0},  // R4 no hit
    {32'h0000_8004, 1'b0, 1'b1, 1'b0},  // R1 disabled window
    {32'h0000_5080, 1'b0, 1'b0, 1'b1},  // R3 user read
    {32'h0000_5080, 1'b1, 1'b1, 1'b0},  // R3 priv write refused
    {32'h0000_0FFF, 1'b0, 1'b1, 1'b0}   // R1 below start
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input logic [31:0] lo, input logic [31:0] hi,
                     input logic en, input logic [3:0] perm);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_lo = lo; cfg_hi = hi; cfg_en = en; cfg_perm = perm;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    #2 chk("R7 clear", 32'(viol_irq), 32'd0);
  endtask

  task automatic xfer(input logic [31:0] addr, input logic wr, input logic priv,
                      input logic ok, input string req);
    logic [3:0] xp;
    @(negedge clk);
    m_haddr = addr; m_htrans = 2'b10; m_hwrite = wr; m_hsize = 3'b010;
    m_hprot = priv ? 4'b0011 : 4'b0001; m_hmaster = 4'h5; m_hwdata = addr ^ 32'h5A5A_0000;
    xp = m_hprot;
    if (prot_ovr_en) xp[1] = prot_ovr_val;
    #2;
    chk({req, " R6 s_htrans"}, 32'(s_htrans), ok ? 32'd2 : 32'd0);
    if (ok) begin
      chk({req, " R5 s_haddr"}, s_haddr, addr);
      chk({req, " R5 s_hwrite"}, 32'(s_hwrite), 32'(wr));
      chk({req, " R5 s_hwdata"}, s_hwdata, addr ^ 32'h5A5A_0000);
      chk({req, " R11 s_hprot"}, 32'(s_hprot), 32'(xp));
    end
    @(negedge clk);
    m_htrans = 2'b00;
    #2;
    if (ok) begin
      chk({req, " R5 hready"}, 32'(m_hready), 32'd1);
      chk({req, " R5 hresp"}, 32'(m_hresp), 32'd0);
      chk({req, " R5 hrdata"}, m_hrdata, 32'hCAFE_0001);
    end else begin
      chk({req, " R6 err1"}, {30'd0, m_hresp, m_hready}, 32'b10);
      @(negedge clk);
      #2 chk({req, " R6 err2"}, {30'd0, m_hresp, m_hready}, 32'b11);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_idx = 0; cfg_lo = 0; cfg_hi = 0; cfg_en = 0; cfg_perm = 0;
    stop_en = 0; prot_ovr_en = 0; prot_ovr_val = 0; flag_clr = 0;
    m_haddr = 0; m_htrans = 0; m_hwrite = 0; m_hsize = 0; m_hprot = 0; m_hmaster = 0; m_hwdata = 0;
    s_hrdata = 32'hCAFE_0001; s_hready = 1'b1; s_hresp = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #2;
    chk("R12 irq", 32'(viol_irq), 32'd0);
    chk("R12 hready", 32'(m_hready), 32'd1);
    chk("R12 hresp", 32'(m_hresp), 32'd0);
    chk("R8 err_addr reset", err_addr, 32'd0);
    chk("R8 err_ctrl reset", 32'(err_ctrl), 32'd0);
    // R12 all windows disabled: any access refused
    xfer(32'h0000_2000, 1'b0, 1'b1, 1'b0, "R12 empty");
    clear_flag();

    cfg(0, 32'h0000_1000, 32'h0000_1FFF, 1'b1, 4'b0001);
    cfg(1, 32'h0000_1000, 32'h0000_3FFF, 1'b1, 4'b1111);
    cfg(2, 32'h0000_8000, 32'h0000_8FFF, 1'b0, 4'b1111);
    cfg(3, 32'h0000_5000, 32'h0000_50FF, 1'b1, 4'b0101);

    for (int i = 0; i < 9; i++) begin
      logic [31:0] a;
      a = VECS[i][34:3];
      xfer(a, VECS[i][2], VECS[i][1], VECS[i][0], $sformatf("vec%0d", i));
      if (!VECS[i][0]) begin
        chk("R7 irq set", 32'(viol_irq), 32'd1);
        chk("R8 err_addr", err_addr, a);
        chk("R8 err_ctrl", 32'(err_ctrl),
            32'({2'b10, 4'h5, VECS[i][1] ? 4'b0011 : 4'b0001, 3'b010, VECS[i][2]}));
        clear_flag();
      end else begin
        chk("R7 irq quiet", 32'(viol_irq), 32'd0);
      end
    end

    // R9 lock-up: after a violation an allowed access is refused, capture frozen
    xfer(32'h0000_4000, 1'b0, 1'b1, 1'b0, "R9 first");
    xfer(32'h0000_2000, 1'b1, 1'b1, 1'b0, "R9 locked");
    chk("R9 err_addr frozen", err_addr, 32'h0000_4000);
    chk("R9 err_ctrl frozen", 32'(err_ctrl), 32'({2'b10, 4'h5, 4'b0011, 3'b010, 1'b0}));
    clear_flag();
    xfer(32'h0000_2000, 1'b1, 1'b1, 1'b1, "R9 resumed");

    // R10 stop mode
    stop_en = 1'b1;
    xfer(32'h0000_2000, 1'b0, 1'b1, 1'b0, "R10 stop");
    chk("R10 irq untouched", 32'(viol_irq), 32'd0);
    chk("R10 err_addr untouched", err_addr, 32'h0000_4000);
    stop_en = 1'b0;
    xfer(32'h0000_2000, 1'b0, 1'b1, 1'b1, "R10 released");

    // R11 override does not change the check
    prot_ovr_en = 1'b1; prot_ovr_val = 1'b1;
    xfer(32'h0000_1FFF, 1'b0, 1'b0, 1'b0, "R11 user still refused");
    chk("R11 irq", 32'(viol_irq), 32'd1);
    clear_flag();
    xfer(32'h0000_2000, 1'b1, 1'b0, 1'b1, "R11 ovr high");
    prot_ovr_val = 1'b0;
    xfer(32'h0000_1000, 1'b0, 1'b1, 1'b1, "R11 ovr low");
    prot_ovr_en = 1'b0;

    // R1 reconfiguration: disabling window 0 lets window 1 decide
    cfg(0, 32'h0000_1000, 32'h0000_1FFF, 1'b0, 4'b0001);
    xfer(32'h0000_1FFF, 1'b0, 1'b0, 1'b1, "R1 window0 off");
    chk("R1 irq", 32'(viol_irq), 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule